// File: doc/BRIEF.md
# FSK Tag Bit Demodulator

This block turns a stream of one-bit zero-crossing samples from a low-frequency reader front end into decoded tag frames. The tag answers with frequency-shift keying: the bench of carrier cycles runs at about 123.2 kHz for a one and about 134.2 kHz for a zero. The block counts rising edges of the sample stream. For every group of sixteen carrier cycles it measures how many sample ticks the group lasted, and from that length it classifies the group as a one, a zero or noise.

Decoded bits enter a 128-bit window from the top, least significant bit first. After each new bit the window is tested for a frame: a fixed preamble in the lowest bits, plus a start byte that matches the end byte. On a hit the block raises a single-cycle strobe. It presents the 64-bit identifier, the received 16-bit checksum, a locally computed checksum verdict, the rewriteable flag and an ident-comparison verdict. These fields hold until the next frame. A synchronous clear restarts edge counting and empties the window.

One clock cycle is one sample, so the clock runs at the sample rate (2 MHz by default).

Top module: `fsk_tag_demod`

## Requirements
- R1: After reset, and on the cycle after `clr` is high, every output is 0 and the bit window is empty. The first rising edge of `sample_in` after reset or clear only sets the timing reference; a rising edge is a sample of 1 following a sample of 0.
- R2: After the reference edge, every sixteenth further rising edge ends a group. The group length is the number of samples from the previous group-ending edge (or the reference edge) up to, but not including, this edge.
- R3: A group length from 249 to 269 inclusive decodes as bit 1.
- R4: A group length from 228 to 248 inclusive decodes as bit 0.
- R5: A group length of 227 or less, or 270 or more, decodes as noise and clears the whole 128-bit window.
- R6: Each decoded bit is inserted at window bit 127 while the window shifts right by one. A frame is considered only when window bits [22:0] equal 23'h7E0000.
- R7: A frame is accepted only if window bits [23:16] equal window bits [111:104]; otherwise no strobe is produced.
- R8: On acceptance, `data` takes window bits [87:24], `crc_rx` takes bits [103:88] and `rw_tag` takes bit 111. These outputs keep their values until the next accepted frame or a clear.
- R9: When `rw_tag` is 1, `ident_ok` is 1 only if window bits [126:112] equal `data[14:0]`. When `rw_tag` is 0, `ident_ok` is 1.
- R10: `crc_ok` is 1 when `crc_rx` equals a CRC-16 over the eight data bytes. The CRC uses polynomial 0x1021 and initial value 0x0000, with no reflection and no final XOR. Bytes are taken `data[7:0]` first, and each byte is taken most significant bit first.
- R11: `frame_valid` is a pulse one cycle wide. It rises two cycles after the sample that carries the group-ending edge of the frame's last bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous restart of timing and window |
| sample_in | input | 1 | Sign of the carrier sample (1 = positive) |
| frame_valid | output | 1 | One-cycle strobe on an accepted frame |
| data | output | 64 | Tag identifier of the last frame |
| crc_rx | output | 16 | Checksum carried in the last frame |
| crc_ok | output | 1 | Computed CRC equals `crc_rx` |
| rw_tag | output | 1 | Frame came from a rewriteable tag |
| ident_ok | output | 1 | Ident field agrees with data (always 1 for read-only) |

## Verification
The noise decision and the window update fall in the same cycle. A noise group shares its decision cycle with what would otherwise be a shift, and it must clear the window rather than shift into it. The bench provokes this by sending a one-bit group, then an out-of-range group of exactly 227 or 270 ticks, then the remaining 127 frame bits. That frame can only be recognised if the earlier one was wiped, because otherwise the one would sit in the preamble zeros. The same judgement applies to a clear issued between two bit groups. Separately, group lengths at both edges of each decoding band are scattered through every frame, so a wrong band edge corrupts `data`.

// File: rtl/fsk_tag_pkg.sv
// Package: shared frame geometry and timing helpers for the FSK tag demodulator.
// Assumes the frame layout is fixed by the tag protocol (128-bit window).
package fsk_tag_pkg;

    localparam int WIN_W       = 128;
    localparam int DATA_W      = 64;
    localparam int CRC_W       = 16;
    localparam int PRE_W       = 23;
    localparam logic [PRE_W-1:0] PRE_VAL = 23'h7E0000;
    localparam int SOF_LSB     = 16;
    localparam int DATA_LSB    = 24;
    localparam int CRC_LSB     = 88;
    localparam int EOF_LSB     = 104;
    localparam int RW_BIT      = 111;
    localparam int IDENT_LSB   = 112;
    localparam int IDENT_CMP_W = 15;

    // Ticks expected for a group of cyc carrier cycles at frequency f.
    function automatic int group_ticks(input int hz, input int cyc, input int f);
        return (hz * cyc) / f;
    endfunction

endpackage

// File: rtl/fsk_edge_timer.sv
// Module: fsk_edge_timer
// Detects rising edges on the sample stream and reports the sample length of
// every group of GROUP_CYCLES edges. The first edge after reset or clear only
// sets the reference. Assumes one sample per clock; the tick counter saturates,
// so very long groups report the all-ones value.
module fsk_edge_timer #(
    parameter int GROUP_CYCLES = 16,
    parameter int CNT_W        = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sample_in,
    output logic             meas_vld,
    output logic [CNT_W-1:0] meas_cnt
);

    localparam int EDGE_W = (GROUP_CYCLES > 1) ? $clog2(GROUP_CYCLES) : 1;
    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(GROUP_CYCLES - 1);
    localparam logic [CNT_W-1:0]  TICK_MAX  = '1;

    logic              prev_q;
    logic              synced_q;
    logic [EDGE_W-1:0] edge_q;
    logic [CNT_W-1:0]  tick_q;
    logic              rise;

    // Purpose: a rising edge is a high sample after a low one.
    assign rise = sample_in & ~prev_q;

    // Purpose: track the reference edge, count edges and ticks, emit group lengths.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prev_q   <= 1'b1;
            synced_q <= 1'b0;
            edge_q   <= '0;
            tick_q   <= '0;
            meas_vld <= 1'b0;
            meas_cnt <= '0;
        end else begin
            prev_q   <= sample_in;
            meas_vld <= 1'b0;
            if (!synced_q) begin
                if (rise) begin
                    synced_q <= 1'b1;
                    tick_q   <= CNT_W'(1);
                    edge_q   <= '0;
                end
            end else if (rise && edge_q == EDGE_LAST) begin
                meas_vld <= 1'b1;
                meas_cnt <= tick_q;
                tick_q   <= CNT_W'(1);
                edge_q   <= '0;
            end else begin
                if (rise) begin
                    edge_q <= edge_q + 1'b1;
                end
                if (tick_q != TICK_MAX) begin
                    tick_q <= tick_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fsk_bit_slicer.sv
// Module: fsk_bit_slicer
// Classifies a measured group length as a one, a zero or noise. The one band
// is tested first, and both bands are open intervals around their nominal
// counts. Assumes ONE_CNT > ZERO_CNT (the lower frequency codes a one).
module fsk_bit_slicer #(
    parameter int CNT_W    = 10,
    parameter int ONE_CNT  = 259,
    parameter int ZERO_CNT = 238,
    parameter int TOL      = 11
) (
    input  logic             meas_vld,
    input  logic [CNT_W-1:0] meas_cnt,
    output logic             bit_vld,
    output logic             bit_val,
    output logic             bit_bad
);

    localparam logic [CNT_W-1:0] ONE_LO  = CNT_W'(ONE_CNT - TOL);
    localparam logic [CNT_W-1:0] ONE_HI  = CNT_W'(ONE_CNT + TOL);
    localparam logic [CNT_W-1:0] ZERO_LO = CNT_W'(ZERO_CNT - TOL);
    localparam logic [CNT_W-1:0] ZERO_HI = CNT_W'(ZERO_CNT + TOL);

    logic in_one;
    logic in_zero;

    // Purpose: compare the length against both open bands.
    always_comb begin
        in_one  = (meas_cnt > ONE_LO)  && (meas_cnt < ONE_HI);
        in_zero = (meas_cnt > ZERO_LO) && (meas_cnt < ZERO_HI);
    end

    // Purpose: pick one before zero and flag anything outside both as noise.
    always_comb begin
        bit_vld = meas_vld && (in_one || in_zero);
        bit_val = in_one;
        bit_bad = meas_vld && !in_one && !in_zero;
    end

endmodule

// File: rtl/fsk_frame_window.sv
// Module: fsk_frame_window
// 128-bit right-shifting window; new bits enter at the top. Noise or a clear
// empties it. new_bit marks the cycle in which the window holds a fresh bit.
module fsk_frame_window
    import fsk_tag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_vld,
    input  logic             bit_val,
    input  logic             bit_bad,
    output logic [WIN_W-1:0] win,
    output logic             new_bit
);

    // Purpose: shift decoded bits in from the top, or wipe on noise.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win     <= '0;
            new_bit <= 1'b0;
        end else begin
            new_bit <= bit_vld;
            if (bit_bad) begin
                win <= '0;
            end else if (bit_vld) begin
                win <= {bit_val, win[WIN_W-1:1]};
            end
        end
    end

endmodule

// File: rtl/fsk_frame_decode.sv
// Module: fsk_frame_decode
// Tests the window for a frame after each new bit and registers the fields,
// the CRC verdict and the ident verdict on acceptance. Assumes new_bit is at
// most one cycle wide per bit.
module fsk_frame_decode
    import fsk_tag_pkg::*;
#(
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
    parameter logic [CRC_W-1:0] CRC_INIT = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              new_bit,
    input  logic [WIN_W-1:0]  win,
    output logic              frame_valid,
    output logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_rx,
    output logic              crc_ok,
    output logic              rw_tag,
    output logic              ident_ok
);

    localparam int NBYTES = DATA_W / 8;

    logic              pre_hit;
    logic              ends_hit;
    logic [DATA_W-1:0] win_data;
    logic [CRC_W-1:0]  win_crc;
    logic [CRC_W-1:0]  crc_calc;
    logic              win_rw;
    logic              win_ident_ok;
    logic              unused_ident_msb;

    // CRC over the data bytes, low byte first, each byte MSB first.
    function automatic logic [CRC_W-1:0] crc_of(input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] c;
        c = CRC_INIT;
        for (int b = 0; b < NBYTES; b++) begin
            c = c ^ {d[8*b +: 8], {(CRC_W-8){1'b0}}};
            for (int k = 0; k < 8; k++) begin
                c = c[CRC_W-1] ? ((c << 1) ^ CRC_POLY) : (c << 1);
            end
        end
        return c;
    endfunction

    // Purpose: decode the candidate fields and verdicts from the window.
    always_comb begin
        pre_hit      = (win[PRE_W-1:0] == PRE_VAL);
        ends_hit     = (win[SOF_LSB +: 8] == win[EOF_LSB +: 8]);
        win_data     = win[DATA_LSB +: DATA_W];
        win_crc      = win[CRC_LSB +: CRC_W];
        win_rw       = win[RW_BIT];
        crc_calc     = crc_of(win_data);
        win_ident_ok = !win_rw ||
                       (win[IDENT_LSB +: IDENT_CMP_W] == win_data[IDENT_CMP_W-1:0]);
    end

    assign unused_ident_msb = win[WIN_W-1];

    // Purpose: strobe and capture an accepted frame; hold fields otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            frame_valid <= 1'b0;
            data        <= '0;
            crc_rx      <= '0;
            crc_ok      <= 1'b0;
            rw_tag      <= 1'b0;
            ident_ok    <= 1'b0;
        end else begin
            frame_valid <= new_bit && pre_hit && ends_hit;
            if (new_bit && pre_hit && ends_hit) begin
                data     <= win_data;
                crc_rx   <= win_crc;
                crc_ok   <= (crc_calc == win_crc);
                rw_tag   <= win_rw;
                ident_ok <= win_ident_ok;
            end
        end
    end

endmodule

// File: rtl/fsk_tag_demod.sv
// Module: fsk_tag_demod (top)
// FSK tag demodulator: edge timer -> bit slicer -> frame window -> decoder.
// Assumes one sample per clock at SAMPLE_HZ and a synchronous active-low reset.
module fsk_tag_demod
    import fsk_tag_pkg::*;
#(
    parameter int SAMPLE_HZ    = 2000000,
    parameter int ONE_HZ       = 123200,
    parameter int ZERO_HZ      = 134200,
    parameter int GROUP_CYCLES = 16,
    parameter logic [15:0] CRC_POLY = 16'h1021,
    parameter logic [15:0] CRC_INIT = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        sample_in,
    output logic        frame_valid,
    output logic [63:0] data,
    output logic [15:0] crc_rx,
    output logic        crc_ok,
    output logic        rw_tag,
    output logic        ident_ok
);

    localparam int ONE_CNT  = group_ticks(SAMPLE_HZ, GROUP_CYCLES, ONE_HZ);
    localparam int ZERO_CNT = group_ticks(SAMPLE_HZ, GROUP_CYCLES, ZERO_HZ);
    localparam int TOL      = (ONE_CNT - ZERO_CNT + 1) >> 1;
    localparam int CNT_W    = $clog2(ONE_CNT + TOL + 1) + 1;

    logic             meas_vld;
    logic [CNT_W-1:0] meas_cnt;
    logic             bit_vld;
    logic             bit_val;
    logic             bit_bad;
    logic [WIN_W-1:0] win;
    logic             new_bit;

    fsk_edge_timer #(
        .GROUP_CYCLES (GROUP_CYCLES),
        .CNT_W        (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .sample_in (sample_in),
        .meas_vld  (meas_vld),
        .meas_cnt  (meas_cnt)
    );

    fsk_bit_slicer #(
        .CNT_W    (CNT_W),
        .ONE_CNT  (ONE_CNT),
        .ZERO_CNT (ZERO_CNT),
        .TOL      (TOL)
    ) u_slicer (
        .meas_vld (meas_vld),
        .meas_cnt (meas_cnt),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .bit_bad  (bit_bad)
    );

    fsk_frame_window u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .bit_vld (bit_vld),
        .bit_val (bit_val),
        .bit_bad (bit_bad),
        .win     (win),
        .new_bit (new_bit)
    );

    fsk_frame_decode #(
        .CRC_POLY (CRC_POLY),
        .CRC_INIT (CRC_INIT)
    ) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .new_bit     (new_bit),
        .win         (win),
        .frame_valid (frame_valid),
        .data        (data),
        .crc_rx      (crc_rx),
        .crc_ok      (crc_ok),
        .rw_tag      (rw_tag),
        .ident_ok    (ident_ok)
    );

endmodule

// File: rtl/fsk_tag_demod_chk.sv
// Module: fsk_tag_demod_chk
// Property checker bound to fsk_tag_demod; observes ports plus the window and
// the slicer's noise flag.
module fsk_tag_demod_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         frame_valid,
    input logic [63:0]  data,
    input logic [15:0]  crc_rx,
    input logic         rw_tag,
    input logic         ident_ok,
    input logic [127:0] win,
    input logic         bit_bad
);

    a_r11_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid)
        else $error("R11 frame_valid wider than one cycle");

    a_r1_clear_silences: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!frame_valid && win == '0 && data == '0))
        else $error("R1 clear did not empty state");

    a_r5_noise_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bit_bad |=> (win == '0))
        else $error("R5 noise did not clear window");

    a_r6_preamble_seen: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (win[22:0] == 23'h7E0000))
        else $error("R6 frame without preamble");

    a_r7_ends_match: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (win[23:16] == win[111:104]))
        else $error("R7 frame with unequal start and end bytes");

    a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_valid && !$past(clr)) |-> ($stable(data) && $stable(crc_rx) && $stable(rw_tag)))
        else $error("R8 fields moved without a frame");

    a_r8_rw_from_window: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (rw_tag == win[111]))
        else $error("R8 rw flag differs from window");

    a_r9_readonly_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !rw_tag) |-> ident_ok)
        else $error("R9 read-only frame flagged ident mismatch");

endmodule

bind fsk_tag_demod fsk_tag_demod_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .frame_valid (frame_valid),
    .data        (data),
    .crc_rx      (crc_rx),
    .rw_tag      (rw_tag),
    .ident_ok    (ident_ok),
    .win         (win),
    .bit_bad     (bit_bad)
);

// File: tb/fsk_tag_demod_tb.sv
// Bench for fsk_tag_demod: a table of frames walked by one loop, then
// directed checks for reset, clear and strobe width.
module fsk_tag_demod_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    typedef struct packed {
        logic [1:0]  mode;     // 0 plain, 1 noise 227 prefix, 2 noise 270 prefix, 3 clear prefix
        logic        rw;
        logic [7:0]  endb;
        logic [63:0] dat;
        logic        good_crc;
        logic [15:0] ident;
        logic        exp_fv;
        logic        exp_ident;
    } row_t;

    localparam row_t ROWS [5] = '{
        '{2'd0, 1'b0, 8'h7E, 64'h0123_4567_89AB_CDEF, 1'b1, 16'h1234, 1'b1, 1'b1},
        '{2'd1, 1'b1, 8'hFE, 64'hFEDC_BA98_7654_3B21, 1'b0, 16'hBB21, 1'b1, 1'b1},
        '{2'd2, 1'b1, 8'hFE, 64'h1357_9BDF_2468_ACE1, 1'b1, 16'h2DE1, 1'b1, 1'b0},
        '{2'd3, 1'b0, 8'h7E, 64'hA5C3_0F96_5AB4_E187, 1'b1, 16'h0F0F, 1'b1, 1'b1},
        '{2'd0, 1'b0, 8'h7F, 64'h0F1E_2D3C_4B5A_6978, 1'b1, 16'h0000, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        sample_in = 1'b0;
    logic        frame_valid;
    logic [63:0] data;
    logic [15:0] crc_rx;
    logic        crc_ok;
    logic        rw_tag;
    logic        ident_ok;

    int n_chk = 0;
    int n_bad = 0;
    int fv_seen = 0;
    int fv_wide = 0;
    logic fv_prev = 1'b0;
    logic [63:0] cap_data;
    logic [15:0] cap_crc;
    logic cap_crc_ok, cap_rw, cap_ident;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_tag_demod u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .sample_in   (sample_in),
        .frame_valid (frame_valid),
        .data        (data),
        .crc_rx      (crc_rx),
        .crc_ok      (crc_ok),
        .rw_tag      (rw_tag),
        .ident_ok    (ident_ok)
    );

    // Strobe monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && frame_valid) begin
            fv_seen++;
            cap_data   = data;
            cap_crc    = crc_rx;
            cap_crc_ok = crc_ok;
            cap_rw     = rw_tag;
            cap_ident  = ident_ok;
            if (fv_prev) fv_wide++;
        end
        fv_prev = frame_valid;
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bit-serial CRC: poly 0x1021, init 0, low byte first, MSB first in a byte.
    function automatic logic [15:0] ref_crc(input logic [63:0] d);
        logic [15:0] c = 16'h0000;
        for (int b = 0; b < 8; b++) begin
            for (int k = 7; k >= 0; k--) begin
                logic fb;
                fb = c[15] ^ d[8*b + k];
                c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
        end
        return c;
    endfunction

    function automatic int len_for(input logic b, input int idx);
        int m = idx % 3;
        if (b) return (m == 0) ? 249 : (m == 1) ? 259 : 269;
        return (m == 0) ? 228 : (m == 1) ? 238 : 248;
    endfunction

    task automatic put_sample(input logic v);
        @(negedge clk);
        sample_in = v;
    endtask

    task automatic send_cycle(input int len);
        for (int i = 0; i < len; i++) put_sample(i < len / 2);
    endtask

    task automatic send_group(input int n);
        for (int c = 0; c < 16; c++) send_cycle(n / 16 + ((c < n % 16) ? 1 : 0));
    endtask

    task automatic send_bits(input logic [127:0] f, input int from);
        for (int i = from; i < 128; i++) send_group(len_for(f[i], i));
    endtask

    task automatic flush();
        send_cycle(16);
        for (int i = 0; i < 8; i++) put_sample(1'b0);
    endtask

    task automatic do_clr();
        @(negedge clk);
        clr = 1'b1;
        sample_in = 1'b0;
        @(negedge clk);
        clr = 1'b0;
        for (int i = 0; i < 4; i++) put_sample(1'b0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 frame_valid", 64'(frame_valid), 64'd0);
        check("R1 data", data, 64'd0);
        check("R1 crc_rx", 64'(crc_rx), 64'd0);
        check("R1 crc_ok", 64'(crc_ok), 64'd0);
        check("R1 rw_tag", 64'(rw_tag), 64'd0);
        check("R1 ident_ok", 64'(ident_ok), 64'd0);
        for (int i = 0; i < 4; i++) put_sample(1'b0);

        for (int r = 0; r < 5; r++) begin
            row_t row;
            logic [127:0] f;
            logic [15:0] crc;
            string tag;
            row = ROWS[r];
            crc = row.good_crc ? ref_crc(row.dat) : (ref_crc(row.dat) ^ 16'h00FF);
            f = '0;
            f[22:17]   = 6'h3F;
            f[23]      = row.rw;
            f[87:24]   = row.dat;
            f[103:88]  = crc;
            f[111:104] = row.endb;
            f[127:112] = row.ident;
            fv_seen = 0;
            case (row.mode)
                2'd1: begin send_group(259); send_group(227); send_bits(f, 1); tag = "R2 R5 R6 R7 noise-low"; end
                2'd2: begin send_group(259); send_group(270); send_bits(f, 1); tag = "R2 R5 R6 R7 noise-high"; end
                2'd3: begin send_group(259); flush(); do_clr(); send_bits(f, 1); tag = "R1 R2 R6 R7 clear"; end
                default: begin send_bits(f, 0); tag = "R2 R6 R7 frame"; end
            endcase
            flush();
            check(tag, 64'(fv_seen), 64'(row.exp_fv));
            if (row.exp_fv && fv_seen == 1) begin
                check("R3 R4 R8 data", cap_data, row.dat);
                check("R8 crc_rx", 64'(cap_crc), 64'(crc));
                check("R8 rw_tag", 64'(cap_rw), 64'(row.rw));
                check("R10 crc_ok", 64'(cap_crc_ok), 64'(row.good_crc));
                check("R9 ident_ok", 64'(cap_ident), 64'(row.exp_ident));
            end
            do_clr();
        end

        // R11: strobe never wider than one cycle
        check("R11 wide strobes", 64'(fv_wide), 64'd0);
        // R1: clear empties held fields
        check("R1 data after clear", data, 64'd0);
        check("R1 crc_ok after clear", 64'(crc_ok), 64'd0);
        summary();
        $finish;
    end

endmodule